// File: doc/BRIEF.md
# Task-File Sector Address Translator

This block turns the four address registers of a disk-style task file into one linear sector number and then into a flash chip and page. The registers are the sector register, the two cylinder registers and the drive/head register. In block-address mode the 28 register bits are concatenated directly. In cylinder/head/sector mode the block multiplies the three coordinates out against a runtime geometry. That geometry is a head count, a sector-per-track count and a programmable cylinder limit.

The result is range-checked against the capacity that the geometry implies. A malformed or out-of-range address raises a not-found flag, and no chip is enabled while that flag is set. A valid address is split into a chip index and a page offset by a programmable shift. Consecutive sectors therefore fill one chip page by page before moving on to the next chip. For multi-sector transfers an advance strobe steps the current address by one sector. The stepped value, expressed in the mode that loaded it, appears on readback outputs so the host can see where the transfer stopped.

Top module: `sector_addr_xlate`

## Requirements
- R1: After reset `addr_valid` and `idnf` are 0, every `chip_en_n` bit is 1 and `rb_drvhd` reads A0h.
- R2: When `load` is high and `tf_drvhd` bit 6 is 1 (block mode), the next `lba` is {`tf_drvhd`[3:0], `tf_cyl_hi`, `tf_cyl_lo`, `tf_sect`}.
- R3: When `load` is high and `tf_drvhd` bit 6 is 0, the next `lba` is ((C × `geo_heads`) + H) × `geo_spt` + S − 1. Here C = {`tf_cyl_hi`, `tf_cyl_lo`}, H = `tf_drvhd`[3:0] and S = `tf_sect`.
- R4: `idnf` is set when `lba` ≥ `geo_max_cyl` × `geo_heads` × `geo_spt`, in either mode. While `idnf` is 1, every `chip_en_n` bit is 1.
- R5: In cylinder/head/sector mode, `idnf` is also set when S is 0, when S > `geo_spt`, or when H ≥ `geo_heads`.
- R6: When `addr_valid` is 1 and `idnf` is 0, let k = `lba` >> `page_shift`. If k < CHIPS, exactly `chip_en_n`[k] is 0; otherwise every bit is 1. `page_addr` holds the low `page_shift` bits of `lba`.
- R7: An `adv` pulse on a valid address that is not flagged raises `lba` by 1 on the next cycle. In block mode the readback outputs then show the new `lba` bits in the same field positions as R2.
- R8: In cylinder/head/sector mode, `adv` steps the sector. After sector `geo_spt` the sector returns to 1 and the head increments. After head `geo_heads` − 1 the head returns to 0 and the cylinder increments. `rb_sect`, `rb_cyl_lo`, `rb_cyl_hi` and `rb_drvhd`[3:0] show the stepped coordinates.
- R9: An `adv` that lifts `lba` to the limit sets `idnf`. `adv` has no effect while `idnf` is 1 or before any `load`.
- R10: When `load` and `adv` are high in the same cycle, `load` wins.
- R11: `rb_drvhd` bits 7 and 5 always read 1. Bit 6 gives the loaded mode and bit 4 gives the loaded drive bit, whatever was written to those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture the task-file registers and translate them |
| adv | input | 1 | Step the current address by one sector |
| tf_sect | input | 8 | Sector register |
| tf_cyl_lo | input | 8 | Cylinder low register |
| tf_cyl_hi | input | 8 | Cylinder high register |
| tf_drvhd | input | 8 | Drive/head register (bit 6 = block mode, bit 4 = drive) |
| geo_heads | input | 5 | Heads per cylinder, 1 to 16 |
| geo_spt | input | 8 | Sectors per track |
| geo_max_cyl | input | 16 | Cylinder limit, default 1000 |
| page_shift | input | 5 | log2 of pages per chip |
| lba | output | 28 | Current linear sector number |
| addr_valid | output | 1 | An address has been loaded |
| idnf | output | 1 | Address not found |
| chip_en_n | output | CHIPS | Active-low chip enables |
| page_addr | output | 28 | Page offset inside the selected chip |
| rb_sect | output | 8 | Readback sector register |
| rb_cyl_lo | output | 8 | Readback cylinder low |
| rb_cyl_hi | output | 8 | Readback cylinder high |
| rb_drvhd | output | 8 | Readback drive/head |

## Verification
The hardest case to reach is the double carry in cylinder/head/sector stepping. That carry occurs only when the last sector of the last head rolls over into a new cylinder. In the same step the linear address can cross the capacity limit. The stimulus loads the first sector of a small geometry and issues one advance per sector across the whole space. The bench tracks the coordinates itself at each step and compares them with the readback fields. Advances continue until the limit is crossed and then one step past it, to show that the flagged address freezes.

// File: rtl/sax_pkg.sv
package sax_pkg;
    localparam int SECT_W  = 8;
    localparam int CYL_W   = 16;
    localparam int HEAD_W  = 4;
    localparam int HCNT_W  = HEAD_W + 1;
    localparam int LBA_W   = 28;
    localparam int WIDE_W  = 32;
    localparam int SHIFT_W = 5;

    typedef struct packed {
        logic              valid;
        logic              idnf;
        logic              lba_mode;
        logic              drv;
        logic [CYL_W-1:0]  cyl;
        logic [HEAD_W-1:0] head;
        logic [SECT_W-1:0] sect;
        logic [LBA_W-1:0]  lba;
    } xl_state_t;
endpackage

// File: rtl/sax_geom.sv
module sax_geom
    import sax_pkg::*;
(
    input  logic [CYL_W-1:0]  cyl,
    input  logic [HEAD_W-1:0] head,
    input  logic [SECT_W-1:0] sect,
    input  logic [HCNT_W-1:0] heads,
    input  logic [SECT_W-1:0] spt,
    input  logic [CYL_W-1:0]  max_cyl,
    output logic [WIDE_W-1:0] chs_lba,
    output logic [WIDE_W-1:0] limit,
    output logic              chs_bad
);
    logic [WIDE_W-1:0] track_idx;

    always_comb begin
        // track index = cylinder * heads + head
        track_idx = WIDE_W'(cyl) * WIDE_W'(heads) + WIDE_W'(head);
        chs_lba   = track_idx * WIDE_W'(spt) + WIDE_W'(sect) - WIDE_W'(1);
        limit     = WIDE_W'(max_cyl) * WIDE_W'(heads) * WIDE_W'(spt);
        chs_bad   = (sect == '0) || (sect > spt) || ({1'b0, head} >= heads);
    end
endmodule

// File: rtl/sax_step.sv
module sax_step
    import sax_pkg::*;
(
    input  logic [CYL_W-1:0]  cyl,
    input  logic [HEAD_W-1:0] head,
    input  logic [SECT_W-1:0] sect,
    input  logic [HCNT_W-1:0] heads,
    input  logic [SECT_W-1:0] spt,
    output logic [CYL_W-1:0]  nxt_cyl,
    output logic [HEAD_W-1:0] nxt_head,
    output logic [SECT_W-1:0] nxt_sect
);
    logic last_sect;
    logic last_head;

    always_comb begin
        last_sect = (sect >= spt);
        last_head = (({1'b0, head} + HCNT_W'(1)) >= heads);
        nxt_cyl   = cyl;
        nxt_head  = head;
        nxt_sect  = sect + SECT_W'(1);
        if (last_sect) begin
            nxt_sect = SECT_W'(1);
            if (last_head) begin
                nxt_head = '0;
                nxt_cyl  = cyl + CYL_W'(1);
            end else begin
                nxt_head = head + HEAD_W'(1);
            end
        end
    end
endmodule

// File: rtl/sax_chip_dec.sv
module sax_chip_dec
    import sax_pkg::*;
#(
    parameter int CHIPS = 4
) (
    input  logic [LBA_W-1:0]   lba,
    input  logic [SHIFT_W-1:0] shift,
    input  logic               access,
    output logic [CHIPS-1:0]   en_n,
    output logic [LBA_W-1:0]   page
);
    logic [LBA_W-1:0] chip_idx;
    logic [LBA_W-1:0] page_mask;

    always_comb begin
        chip_idx  = lba >> shift;
        page_mask = ~({LBA_W{1'b1}} << shift);
        page      = lba & page_mask;
    end

    for (genvar g = 0; g < CHIPS; g++) begin : g_chip
        assign en_n[g] = ~(access && (chip_idx == LBA_W'(g)));
    end
endmodule

// File: rtl/sector_addr_xlate.sv
module sector_addr_xlate
    import sax_pkg::*;
#(
    parameter int CHIPS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                adv,
    input  logic [SECT_W-1:0]   tf_sect,
    input  logic [7:0]          tf_cyl_lo,
    input  logic [7:0]          tf_cyl_hi,
    input  logic [7:0]          tf_drvhd,
    input  logic [HCNT_W-1:0]   geo_heads,
    input  logic [SECT_W-1:0]   geo_spt,
    input  logic [CYL_W-1:0]    geo_max_cyl,
    input  logic [SHIFT_W-1:0]  page_shift,
    output logic [LBA_W-1:0]    lba,
    output logic                addr_valid,
    output logic                idnf,
    output logic [CHIPS-1:0]    chip_en_n,
    output logic [LBA_W-1:0]    page_addr,
    output logic [7:0]          rb_sect,
    output logic [7:0]          rb_cyl_lo,
    output logic [7:0]          rb_cyl_hi,
    output logic [7:0]          rb_drvhd
);
    localparam int MODE_BIT = 6;
    localparam int DRV_BIT  = 4;

    xl_state_t s_d, s_q;

    logic [CYL_W-1:0]  tf_cyl;
    logic [WIDE_W-1:0] chs_lba;
    logic [WIDE_W-1:0] limit;
    logic              chs_bad;
    logic [CYL_W-1:0]  step_cyl;
    logic [HEAD_W-1:0] step_head;
    logic [SECT_W-1:0] step_sect;

    assign tf_cyl = {tf_cyl_hi, tf_cyl_lo};

    sax_geom u_geom (
        .cyl     (tf_cyl),
        .head    (tf_drvhd[HEAD_W-1:0]),
        .sect    (tf_sect),
        .heads   (geo_heads),
        .spt     (geo_spt),
        .max_cyl (geo_max_cyl),
        .chs_lba (chs_lba),
        .limit   (limit),
        .chs_bad (chs_bad)
    );

    sax_step u_step (
        .cyl      (s_q.cyl),
        .head     (s_q.head),
        .sect     (s_q.sect),
        .heads    (geo_heads),
        .spt      (geo_spt),
        .nxt_cyl  (step_cyl),
        .nxt_head (step_head),
        .nxt_sect (step_sect)
    );

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.valid    = 1'b1;
            s_d.lba_mode = tf_drvhd[MODE_BIT];
            s_d.drv      = tf_drvhd[DRV_BIT];
            s_d.cyl      = tf_cyl;
            s_d.head     = tf_drvhd[HEAD_W-1:0];
            s_d.sect     = tf_sect;
            if (tf_drvhd[MODE_BIT]) begin
                s_d.lba  = {tf_drvhd[HEAD_W-1:0], tf_cyl_hi, tf_cyl_lo, tf_sect};
                s_d.idnf = (WIDE_W'(s_d.lba) >= limit);
            end else begin
                s_d.lba  = chs_lba[LBA_W-1:0];
                s_d.idnf = chs_bad || (chs_lba >= limit);
            end
        end else if (adv && s_q.valid && !s_q.idnf) begin
            s_d.lba  = s_q.lba + LBA_W'(1);
            s_d.idnf = (WIDE_W'(s_d.lba) >= limit);
            if (!s_q.lba_mode) begin
                s_d.cyl  = step_cyl;
                s_d.head = step_head;
                s_d.sect = step_sect;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    sax_chip_dec #(.CHIPS(CHIPS)) u_dec (
        .lba    (s_q.lba),
        .shift  (page_shift),
        .access (s_q.valid && !s_q.idnf),
        .en_n   (chip_en_n),
        .page   (page_addr)
    );

    always_comb begin
        lba        = s_q.lba;
        addr_valid = s_q.valid;
        idnf       = s_q.idnf;
        if (s_q.lba_mode) begin
            rb_sect   = s_q.lba[7:0];
            rb_cyl_lo = s_q.lba[15:8];
            rb_cyl_hi = s_q.lba[23:16];
            rb_drvhd  = {1'b1, 1'b1, 1'b1, s_q.drv, s_q.lba[27:24]};
        end else begin
            rb_sect   = s_q.sect;
            rb_cyl_lo = s_q.cyl[7:0];
            rb_cyl_hi = s_q.cyl[15:8];
            rb_drvhd  = {1'b1, 1'b0, 1'b1, s_q.drv, s_q.head};
        end
    end
endmodule

// File: rtl/sector_addr_xlate_chk.sv
module sector_addr_xlate_chk #(
    parameter int CHIPS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic             adv,
    input logic [27:0]      lba,
    input logic             addr_valid,
    input logic             idnf,
    input logic [CHIPS-1:0] chip_en_n,
    input logic [7:0]       rb_drvhd
);
    // R1: nothing enabled before an address exists
    p_quiet_invalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> (chip_en_n == {CHIPS{1'b1}}));

    // R4: flagged address never reaches a chip
    p_no_access_idnf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        idnf |-> (chip_en_n == {CHIPS{1'b1}}));

    // R6: at most one chip enabled
    p_one_chip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~chip_en_n));

    // R7: advance steps by exactly one sector
    p_adv_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !idnf && adv && !load) |=> (lba == $past(lba) + 28'd1));

    // R9: a flagged address is frozen until the next load
    p_idnf_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idnf && !load) |=> (idnf && $stable(lba)));

    // R10: load always yields a loaded address
    p_load_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr_valid);

    // R11: fixed readback bits
    p_fixed_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rb_drvhd[7] && rb_drvhd[5]);
endmodule

bind sector_addr_xlate sector_addr_xlate_chk #(.CHIPS(CHIPS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .adv        (adv),
    .lba        (lba),
    .addr_valid (addr_valid),
    .idnf       (idnf),
    .chip_en_n  (chip_en_n),
    .rb_drvhd   (rb_drvhd)
);

// File: tb/sector_addr_xlate_tb_top.sv
module sector_addr_xlate_tb_top;
    localparam int CHIPS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic        adv = 1'b0;
    logic [7:0]  tf_sect = '0, tf_cyl_lo = '0, tf_cyl_hi = '0, tf_drvhd = '0;
    logic [4:0]  geo_heads = 5'd2;
    logic [7:0]  geo_spt = 8'd4;
    logic [15:0] geo_max_cyl = 16'd3;
    logic [4:0]  page_shift = 5'd3;
    logic [27:0] lba, page_addr;
    logic        addr_valid, idnf;
    logic [CHIPS-1:0] chip_en_n;
    logic [7:0]  rb_sect, rb_cyl_lo, rb_cyl_hi, rb_drvhd;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sector_addr_xlate #(.CHIPS(CHIPS)) dut_i (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
        .tf_sect(tf_sect), .tf_cyl_lo(tf_cyl_lo), .tf_cyl_hi(tf_cyl_hi), .tf_drvhd(tf_drvhd),
        .geo_heads(geo_heads), .geo_spt(geo_spt), .geo_max_cyl(geo_max_cyl), .page_shift(page_shift),
        .lba(lba), .addr_valid(addr_valid), .idnf(idnf), .chip_en_n(chip_en_n), .page_addr(page_addr),
        .rb_sect(rb_sect), .rb_cyl_lo(rb_cyl_lo), .rb_cyl_hi(rb_cyl_hi), .rb_drvhd(rb_drvhd)
    );

    task automatic chk(input string tag, input longint got, input longint exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_load(input logic [7:0] s, input logic [7:0] lo, input logic [7:0] hi,
                           input logic [7:0] dh, input logic with_adv);
        @(negedge clk);
        tf_sect = s; tf_cyl_lo = lo; tf_cyl_hi = hi; tf_drvhd = dh;
        load = 1'b1; adv = with_adv;
        @(negedge clk);
        load = 1'b0; adv = 1'b0;
    endtask

    task automatic do_adv();
        @(negedge clk);
        adv = 1'b1;
        @(negedge clk);
        adv = 1'b0;
    endtask

    // check lba, idnf, chip enables and page for a loaded address
    task automatic chk_addr(input string tag, input longint exp_lba, input bit exp_idnf, input bit cmp_lba);
        longint pages;
        longint idx;
        logic [CHIPS-1:0] exp_en;
        pages  = longint'(1) << page_shift;
        exp_en = {CHIPS{1'b1}};
        chk({tag, " valid"}, addr_valid, 1);
        chk({tag, " idnf"}, idnf, exp_idnf);
        if (cmp_lba) chk({tag, " lba"}, lba, exp_lba);
        if (!exp_idnf && cmp_lba) begin
            idx = exp_lba / pages;
            if (idx < CHIPS) exp_en[idx] = 1'b0;
            chk({tag, " page R6"}, page_addr, exp_lba % pages);
        end
        chk({tag, " chip_en_n R6"}, chip_en_n, exp_en);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", addr_valid, 0);
        chk("R1 idnf", idnf, 0);
        chk("R1 chip_en_n", chip_en_n, 4'hF);
        chk("R1 rb_drvhd", rb_drvhd, 8'hA0);

        // R9 advance with no address loaded
        do_adv();
        chk("R9 adv before load valid", addr_valid, 0);
        chk("R9 adv before load lba", lba, 0);

        // R3/R4/R5 sweep: heads 2, spt 4, max cyl 3 -> limit 24, 8 pages per chip
        for (int c = 0; c < 5; c++)
            for (int h = 0; h < 3; h++)
                for (int s = 0; s < 6; s++) begin
                    bit bad;
                    longint e;
                    bad = (s == 0) || (s > 4) || (h >= 2);
                    e   = (c * 2 + h) * 4 + s - 1;
                    do_load(8'(s), 8'(c), 8'h00, 8'hA0 | 8'(h), 1'b0);
                    if (bad) chk_addr("R5 chs malformed", 0, 1'b1, 1'b0);
                    else if (e >= 24) chk_addr("R4 chs range", e, 1'b1, 1'b1);
                    else chk_addr("R3 chs", e, 1'b0, 1'b1);
                end

        // R2/R4 block-mode sweep
        for (int v = 0; v < 31; v++) begin
            do_load(8'(v), 8'h00, 8'h00, 8'hE0, 1'b0);
            chk_addr((v >= 24) ? "R4 lba range" : "R2 lba", v, v >= 24, 1'b1);
        end

        // R2/R6/R11 wide address with large geometry, chip index beyond CHIPS
        geo_heads = 5'd16; geo_spt = 8'd255; geo_max_cyl = 16'hFFFF; page_shift = 5'd8;
        do_load(8'h3D, 8'h2C, 8'h1B, 8'h4A, 1'b0);
        chk_addr("R2 wide", 28'hA1B2C3D, 1'b0, 1'b1);
        chk("R11 rb_drvhd", rb_drvhd, 8'hEA);
        chk("R2 rb_cyl_hi", rb_cyl_hi, 8'h1B);
        do_load(8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0);
        chk_addr("R4 top lba", 28'hFFFFFFF, 1'b1, 1'b1);
        chk("R11 drive bit", rb_drvhd, 8'hFF);

        // R3/R6 default cylinder limit, 16 sectors, shift 10
        geo_heads = 5'd1; geo_spt = 8'd16; geo_max_cyl = 16'd1000; page_shift = 5'd10;
        do_load(8'd16, 8'hE7, 8'h03, 8'hA0, 1'b0);   // cyl 999, last sector
        chk_addr("R3 last sector", 16'h3E7F, 1'b0, 1'b1);
        do_load(8'd1, 8'hE8, 8'h03, 8'hA0, 1'b0);    // cyl 1000
        chk_addr("R4 cyl at limit", 16'h3E80, 1'b1, 1'b1);

        // R8/R9 CHS stepping over the whole small space
        geo_heads = 5'd2; geo_spt = 8'd4; geo_max_cyl = 16'd3; page_shift = 5'd3;
        begin
            int c, h, s;
            c = 0; h = 0; s = 1;
            do_load(8'd1, 8'd0, 8'd0, 8'hA0, 1'b0);
            for (int k = 1; k < 24; k++) begin
                do_adv();
                s++;
                if (s > 4) begin
                    s = 1; h++;
                    if (h >= 2) begin h = 0; c++; end
                end
                chk_addr("R8 chs step", k, 1'b0, 1'b1);
                chk("R8 rb_sect", rb_sect, s);
                chk("R8 rb_cyl_lo", rb_cyl_lo, c);
                chk("R8 rb_drvhd", rb_drvhd, 8'hA0 | 8'(h));
            end
            do_adv();
            chk_addr("R9 step to limit", 24, 1'b1, 1'b1);
            do_adv();
            chk_addr("R9 frozen", 24, 1'b1, 1'b1);
        end

        // R7/R9 block-mode stepping
        do_load(8'd20, 8'h00, 8'h00, 8'hF0, 1'b0);
        for (int k = 21; k < 24; k++) begin
            do_adv();
            chk_addr("R7 lba step", k, 1'b0, 1'b1);
            chk("R7 rb_sect", rb_sect, k);
            chk("R7 rb_drvhd", rb_drvhd, 8'hF0);
        end
        do_adv();
        chk_addr("R9 lba step to limit", 24, 1'b1, 1'b1);

        // R7 carry into upper readback fields
        geo_heads = 5'd16; geo_spt = 8'd255; geo_max_cyl = 16'hFFFF; page_shift = 5'd8;
        do_load(8'hFF, 8'hFF, 8'h00, 8'hE0, 1'b0);
        do_adv();
        chk("R7 carry lba", lba, 28'h10000);
        chk("R7 carry rb_cyl_hi", rb_cyl_hi, 8'h01);
        chk("R7 carry rb_sect", rb_sect, 8'h00);

        // R10 load and advance together
        do_load(8'd5, 8'h00, 8'h00, 8'hE0, 1'b1);
        chk("R10 load wins", lba, 5);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule